// File: doc/BRIEF.md
# Pixel Blink Modifier

This block sits in a video pixel stream and changes the pixels that are marked as blinking, but only while the blink phase is active. It decides whether a pixel blinks with a masked compare. The bits of the pixel that the mask selects must equal the same bits of a programmable pattern. A mask with one bit plane set therefore marks half of all pixel values. A mask with every bit set marks exactly one value. An all-zero mask marks every pixel.

A matching pixel gets one of four effects:

- **Blank**: the pixel is forced to zero, so the object vanishes and reappears from one phase to the next.
- **Brighter**: a one-bit right shift with the top bit forced to 1.
- **Dimmer**: the same shift with the top bit forced to 0.
- **Offset**: a programmable offset is added, wrapping within the field.

The shift and offset effects act per colour field, according to the pixel layout:

- In 4 and 8 bpp they act on the whole low word.
- In 16 bpp (5-6-5) and 24 bpp (8-8-8) they act on the blue, green and red fields separately.

The result is registered once, and a valid strobe travels alongside it.

Top module: `pix_blink_mod`

## Requirements
- R1: A pixel is selected for blinking when `((pix_i ^ pattern_i) & mask_i) == 0`. A zero mask selects every pixel, and a full mask selects only the value equal to the pattern.
- R2: When `blink_on_i` is 0, or the pixel is not selected, the output equals the input pixel.
- R3: With `mode_i` = 0 (blank), a selected pixel in the active phase becomes 0 in all 24 bits.
- R4: With `mode_i` = 1 (brighter), each active field of W bits becomes `{1'b1, field[W-1:1]}`.
- R5: With `mode_i` = 2 (dimmer), each active field of W bits becomes `{1'b0, field[W-1:1]}`.
- R6: With `mode_i` = 3 (offset), each active field becomes `(field + offset field at the same bit position)` modulo 2^W.
- R7: The value of `fmt_i` selects the active fields:
  - 0: bits [3:0].
  - 1: bits [7:0].
  - 2: bits [4:0], [10:5] and [15:11].
  - 3: bits [7:0], [15:8] and [23:16].
  
  For the brighter, dimmer and offset effects, bits outside the active fields pass through unchanged.
- R8: `valid_o` equals `valid_i` from the previous clock edge. A pixel accepted at edge N appears on `pix_o` after edge N.
- R9: While `valid_i` is 0, `pix_o` holds its last value.
- R10: While `rst_ni` is low, `valid_o` and `pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| pix_i | input | 24 | Input pixel word |
| blink_on_i | input | 1 | Blink phase active |
| mode_i | input | 2 | Effect: 0 blank, 1 brighter, 2 dimmer, 3 offset |
| fmt_i | input | 2 | Layout: 0 4bpp, 1 8bpp, 2 16bpp 565, 3 24bpp 888 |
| mask_i | input | 24 | Blink select mask |
| pattern_i | input | 24 | Blink select pattern |
| offset_i | input | 24 | Offset added in offset mode, per field |
| valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Output pixel word |

## Verification
The assertions check the following on every cycle:
- The one-cycle valid alignment.
- That the output holds while no pixel arrives.
- Pass-through for unselected pixels and for the inactive phase.
- Zeroing in blank mode.
- The forced top bits in 24 bpp brighter and dimmer modes.
- That the bits above the 8 bpp field are kept.

Only the bench scenarios show the exact field values. These cover:
- Shifting in each layout.
- Modular wrap of the offset in the 5-6-5 and 8-8-8 fields.
- Single-value selection with a full mask.
- The reset state.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int PIX_W = 24;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    MODE_BLANK  = 2'd0,
    MODE_BRIGHT = 2'd1,
    MODE_DIM    = 2'd2,
    MODE_OFFSET = 2'd3
  } mode_e;

  typedef enum logic [SEL_W-1:0] {
    FMT_4   = 2'd0,
    FMT_8   = 2'd1,
    FMT_565 = 2'd2,
    FMT_888 = 2'd3
  } fmt_e;
endpackage

// File: rtl/pbm_match.sv
module pbm_match #(
  parameter int W = 24
) (
  input  logic [W-1:0] pix_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] pattern_i,
  output logic         hit_o
);
  assign hit_o = ~|((pix_i ^ pattern_i) & mask_i);
endmodule

// File: rtl/pbm_field_op.sv
module pbm_field_op #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] off_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] res_o
);
  import pbm_pkg::*;

  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_BRIGHT: res_o = {1'b1, val_i[W-1:1]};
      MODE_DIM:    res_o = {1'b0, val_i[W-1:1]};
      MODE_OFFSET: res_o = val_i + off_i;   // wraps mod 2^W
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/pix_blink_mod.sv
module pix_blink_mod
  import pbm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [23:0] pix_i,
  input  logic        blink_on_i,
  input  logic [1:0]  mode_i,
  input  logic [1:0]  fmt_i,
  input  logic [23:0] mask_i,
  input  logic [23:0] pattern_i,
  input  logic [23:0] offset_i,
  output logic        valid_o,
  output logic [23:0] pix_o
);
  localparam int NF = 3;
  localparam int W8 = 8;
  localparam int W4 = 4;
  localparam int LO565 [NF] = '{0, 5, 11};
  localparam int WD565 [NF] = '{5, 6, 5};

  logic             hit;
  logic [W4-1:0]    res4;
  logic [W8-1:0]    res8;
  wire  [15:0]      res565;
  wire  [PIX_W-1:0] res888;
  logic [PIX_W-1:0] eff;
  logic [PIX_W-1:0] pix_q;
  logic             valid_q;

  pbm_match #(.W(PIX_W)) u_match (
    .pix_i     (pix_i),
    .mask_i    (mask_i),
    .pattern_i (pattern_i),
    .hit_o     (hit)
  );

  pbm_field_op #(.W(W4)) u_op4 (
    .val_i  (pix_i[W4-1:0]),
    .off_i  (offset_i[W4-1:0]),
    .mode_i (mode_i),
    .res_o  (res4)
  );

  pbm_field_op #(.W(W8)) u_op8 (
    .val_i  (pix_i[W8-1:0]),
    .off_i  (offset_i[W8-1:0]),
    .mode_i (mode_i),
    .res_o  (res8)
  );

  for (genvar g = 0; g < NF; g++) begin : g_565
    pbm_field_op #(.W(WD565[g])) u_op (
      .val_i  (pix_i[LO565[g] +: WD565[g]]),
      .off_i  (offset_i[LO565[g] +: WD565[g]]),
      .mode_i (mode_i),
      .res_o  (res565[LO565[g] +: WD565[g]])
    );
  end

  for (genvar g = 0; g < NF; g++) begin : g_888
    pbm_field_op #(.W(W8)) u_op (
      .val_i  (pix_i[g*W8 +: W8]),
      .off_i  (offset_i[g*W8 +: W8]),
      .mode_i (mode_i),
      .res_o  (res888[g*W8 +: W8])
    );
  end

  always_comb begin
    eff = pix_i;
    if (blink_on_i && hit) begin
      if (mode_e'(mode_i) == MODE_BLANK) begin
        eff = '0;
      end else begin
        unique case (fmt_e'(fmt_i))
          FMT_4:   eff = {pix_i[PIX_W-1:W4], res4};
          FMT_8:   eff = {pix_i[PIX_W-1:W8], res8};
          FMT_565: eff = {pix_i[PIX_W-1:16], res565};
          default: eff = res888;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) pix_q <= eff;
    end
  end

  assign valid_o = valid_q;
  assign pix_o   = pix_q;
endmodule

// File: rtl/pbm_chk.sv
module pbm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [23:0] pix_i,
  input logic        blink_on_i,
  input logic [1:0]  mode_i,
  input logic [1:0]  fmt_i,
  input logic [23:0] mask_i,
  input logic [23:0] pattern_i,
  input logic        valid_o,
  input logic [23:0] pix_o
);
  logic sel;
  assign sel = ((pix_i & mask_i) == (pattern_i & mask_i));

  a_r8_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pix_o));
  a_r2_phase_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !blink_on_i) |=> pix_o == $past(pix_i));
  a_r1_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel) |=> pix_o == $past(pix_i));
  a_r3_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && blink_on_i && sel && mode_i == 2'd0) |=> pix_o == 24'h0);
  a_r4_bright_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && blink_on_i && sel && mode_i == 2'd1 && fmt_i == 2'd3)
      |=> (pix_o[23] && pix_o[15] && pix_o[7]));
  a_r5_dim_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && blink_on_i && sel && mode_i == 2'd2 && fmt_i == 2'd3)
      |=> (!pix_o[23] && !pix_o[15] && !pix_o[7]));
  a_r7_upper_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == 2'd1 && mode_i != 2'd0) |=> pix_o[23:8] == $past(pix_i[23:8]));
endmodule

bind pix_blink_mod pbm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .pix_i      (pix_i),
  .blink_on_i (blink_on_i),
  .mode_i     (mode_i),
  .fmt_i      (fmt_i),
  .mask_i     (mask_i),
  .pattern_i  (pattern_i),
  .valid_o    (valid_o),
  .pix_o      (pix_o)
);

// File: tb/sim_pix_blink_mod.sv
module sim_pix_blink_mod;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] pix_i = '0;
  logic        blink_on_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [23:0] mask_i = '0;
  logic [23:0] pattern_i = '0;
  logic [23:0] offset_i = '0;
  logic        valid_o;
  logic [23:0] pix_o;

  int unsigned n_tests = 0;
  int unsigned n_fail = 0;
  logic [23:0] last_out = '0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pix_blink_mod u0 (.*);

  function automatic logic [23:0] fld(input logic [23:0] r, input logic [23:0] p,
                                      input logic [23:0] o, input int lo, input int w,
                                      input logic [1:0] m);
    logic [23:0] msk, v, ov, nv;
    msk = (24'd1 << w) - 24'd1;
    v   = (p >> lo) & msk;
    ov  = (o >> lo) & msk;
    case (m)
      2'd1:    nv = ((v >> 1) | (24'd1 << (w - 1))) & msk;
      2'd2:    nv = (v >> 1) & msk;
      default: nv = (v + ov) & msk;
    endcase
    return (r & ~(msk << lo)) | (nv << lo);
  endfunction

  function automatic logic [23:0] model(input logic [23:0] p, input logic on,
                                        input logic [1:0] m, input logic [1:0] f,
                                        input logic [23:0] mk, input logic [23:0] pt,
                                        input logic [23:0] o);
    logic [23:0] r;
    if (!on || ((p & mk) != (pt & mk))) return p;
    if (m == 2'd0) return 24'h0;
    r = p;
    case (f)
      2'd0: r = fld(r, p, o, 0, 4, m);
      2'd1: r = fld(r, p, o, 0, 8, m);
      2'd2: begin
        r = fld(r, p, o, 0, 5, m);
        r = fld(r, p, o, 5, 6, m);
        r = fld(r, p, o, 11, 5, m);
      end
      default: begin
        r = fld(r, p, o, 0, 8, m);
        r = fld(r, p, o, 8, 8, m);
        r = fld(r, p, o, 16, 8, m);
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 ns after the next posedge.
  task automatic step(input string tag, input logic v, input logic [23:0] p, input logic on,
                      input logic [1:0] m, input logic [1:0] f, input logic [23:0] mk,
                      input logic [23:0] pt, input logic [23:0] o);
    logic [23:0] exp;
    @(negedge clk_i);
    valid_i = v; pix_i = p; blink_on_i = on; mode_i = m; fmt_i = f;
    mask_i = mk; pattern_i = pt; offset_i = o;
    exp = v ? model(p, on, m, f, mk, pt, o) : last_out;
    @(posedge clk_i);
    #1;
    check({tag, " R8 valid"}, {23'd0, valid_o}, {23'd0, v});
    check(tag, pix_o, exp);
    last_out = exp;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #35;
    check("R10 reset valid", {23'd0, valid_o}, 24'd0);
    check("R10 reset data", pix_o, 24'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    step("R4 bright 888", 1, 24'h123456, 1, 2'd1, 2'd3, 24'h0, 24'h0, 24'h0);
    check("R4 bright 888 literal", pix_o, 24'h899AAB);
    step("R5 dim 888", 1, 24'h123456, 1, 2'd2, 2'd3, 24'h0, 24'h0, 24'h0);
    check("R5 dim 888 literal", pix_o, 24'h091A2B);
    step("R6 offset wrap 888", 1, 24'hFF8001, 1, 2'd3, 2'd3, 24'h0, 24'h0, 24'h0290FF);
    check("R6 wrap literal", pix_o, 24'h011000);
    step("R6 offset wrap 565", 1, 24'h00FFFF, 1, 2'd3, 2'd2, 24'h0, 24'h0, 24'h000821);
    step("R7 bright 4bpp keeps upper", 1, 24'hABCDE6, 1, 2'd1, 2'd0, 24'h0, 24'h0, 24'h0);
    check("R7 4bpp literal", pix_o, 24'hABCDEB);
    step("R7 dim 8bpp", 1, 24'h5A5AF1, 1, 2'd2, 2'd1, 24'h0, 24'h0, 24'h0);
    step("R3 blank", 1, 24'h777777, 1, 2'd0, 2'd3, 24'h0, 24'h0, 24'h0);
    step("R2 phase off", 1, 24'h777777, 0, 2'd0, 2'd3, 24'h0, 24'h0, 24'h0);
    step("R1 full mask hit", 1, 24'h00002A, 1, 2'd0, 2'd1, 24'hFFFFFF, 24'h00002A, 24'h0);
    step("R1 full mask miss", 1, 24'h00002B, 1, 2'd0, 2'd1, 24'hFFFFFF, 24'h00002A, 24'h0);
    step("R1 one plane miss", 1, 24'h000010, 1, 2'd2, 2'd1, 24'h000010, 24'h0, 24'h0);
    step("R9 hold", 0, 24'h123123, 1, 2'd0, 2'd3, 24'h0, 24'h0, 24'h0);
    step("R9 hold2", 0, 24'hFEDCBA, 0, 2'd1, 2'd0, 24'h0, 24'h0, 24'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [23:0] mk;
      logic [23:0] pt;
      mk = ($urandom % 3 == 0) ? 24'h0 : ($urandom & 24'h0F0F0F);
      pt = $urandom;
      step("R1 R2 R4 R5 R6 R7 random", ($urandom % 5) != 0, $urandom, $urandom % 2,
           2'($urandom), 2'($urandom), mk, pt, $urandom);
    end

    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R10 async reset valid", {23'd0, valid_o}, 24'd0);
    check("R10 async reset data", pix_o, 24'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule